// File: doc/BRIEF.md
# MDIO Link-Speed Configuration Sequencer

This block is a management-bus master with a small control sequencer in front of it. A single start pulse runs a fixed job. If asked, the job first tells an external PHY to restart auto-negotiation. It then reads the PHY's status register over and over until the auto-negotiation-complete flag comes back set. It takes the resolved link speed from that status word and writes a matching speed code to the configuration register of two RGMII converters. The two converters share the bus and answer at fixed addresses 7 and 8. Both ports of the link are assumed to run at the same rate, so one status read sets the code for both converters.

The block produces MDC, drives the MDIO output and its output enable, and samples the MDIO input. The output enable drives an external tri-state buffer. When the job finishes it pulses `done` and shows the detected speed. If polling times out, or if the PHY reports a reserved speed value, it raises `error` instead.

The sequencer states are IDLE, ANEG, POLL, EVAL, WR_A, WR_B, DONE and FAIL. The transitions are:

- IDLE→ANEG on start with restart requested.
- IDLE→POLL on start without a restart request.
- ANEG→POLL when the frame completes.
- POLL→EVAL when the read frame completes.
- EVAL→POLL when the complete flag is clear and polls remain.
- EVAL→FAIL when polls are exhausted or the speed is reserved.
- EVAL→WR_A when the complete flag is set and the speed is legal.
- WR_A→WR_B and WR_B→DONE when each frame completes.
- DONE→IDLE and FAIL→IDLE unconditionally.

The frame engine has two states, FRM_IDLE and FRM_SHIFT. It moves from FRM_IDLE to FRM_SHIFT on a request, and back on the MDC falling edge after the 64th bit.

Top module: `mdio_speed_cfg`

## Requirements
- R1: After reset, `mdc`, `mdio_oe`, `busy`, `done` and `error` are low and `mdio_o` is high.
- R2: A start pulse with `restart_an` high first writes value AN_RESTART_VAL (default 0x1200) to register CTRL_REG (default 0) of PHY address PHY_ADDR (default 1). With `restart_an` low, no write goes to the PHY.
- R3: Every frame is 64 bits, sent MSB first, in this order: 32 ones, start bits 01, opcode (01 write, 10 read), 5-bit device address, 5-bit register address, two turnaround bits, and 16 data bits. A write frame drives the turnaround as 10.
- R4: `mdio_o` and `mdio_oe` change only in the clock cycle in which MDC falls. On a read, `mdio_oe` is low from the first turnaround bit to the end of the frame, and the input is sampled on MDC rising edges.
- R5: The status register STAT_REG (default 0x11) of PHY_ADDR is read until bit AN_BIT (default 11) is 1. If POLL_LIMIT reads all show it clear, the job ends with `error` and writes nothing to the converters.
- R6: The speed field is status bits [SPD_HI:SPD_HI-1] (default [15:14]). Value 10 means 1 Gb/s and gives code 0x0140. Value 01 means 100 Mb/s and gives code 0x2100. Value 00 means 10 Mb/s and gives code 0x0100. Value 11 ends the job with `error`. The `speed` output shows the field value after a successful job.
- R7: After a legal speed, register 0x10 of address 7 and then register 0x10 of address 8 are each written once with the same code. Both writes come after the last status read.
- R8: `done` is a one-cycle pulse that follows the second converter write. It never occurs together with `error`.
- R9: A start pulse while `busy` is high is ignored.
- R10: `error` stays high after a failed job until the next accepted start, which clears it. `busy` is low once the job ends.
- R11: MDC is low and high for CLK_DIV system clocks each. The default of 40 gives 2.5 MHz from a 200 MHz clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that starts a job |
| restart_an | input | 1 | Sampled with start: restart auto-negotiation first |
| mdio_i | input | 1 | MDIO input from the pad |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output data |
| mdio_oe | output | 1 | MDIO output enable |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle pulse when both converters are written |
| error | output | 1 | Timeout or reserved speed, held until next start |
| speed | output | 2 | Resolved speed field: 00 = 10M, 01 = 100M, 10 = 1G |

## Verification
A wrong sequencer state shows up at the bus within one frame, about 64 MDC periods. It appears as a frame to the wrong address or register, a missing or extra status read, or a converter write that comes before the final status read. A fault in the frame engine shows within a single bit time. The slave model sees a broken start, opcode or turnaround pattern, or finds the output enable still asserted while it drives read data. Faults in speed decoding show only at the end of the job, in the code written to the converters and in the `speed` output. Faults in the poll counter show as the wrong number of status reads before `error`.

// File: rtl/mdio_cfg_pkg.sv
package mdio_cfg_pkg;

    localparam int FRAME_BITS = 64;
    localparam int TA_POS     = 46;
    localparam int DATA_POS   = 48;

    typedef enum logic [3:0] {
        SEQ_IDLE, SEQ_ANEG, SEQ_POLL, SEQ_EVAL,
        SEQ_WR_A, SEQ_WR_B, SEQ_DONE, SEQ_FAIL
    } seq_state_e;

    typedef enum logic [0:0] {
        FRM_IDLE, FRM_SHIFT
    } frm_state_e;

    typedef struct packed {
        logic        rd;
        logic [4:0]  dev;
        logic [4:0]  regad;
        logic [15:0] wdata;
    } mdio_cmd_t;

    function automatic logic [15:0] speed_code(input logic [1:0] fld);
        case (fld)
            2'b10:   speed_code = 16'h0140;
            2'b01:   speed_code = 16'h2100;
            2'b00:   speed_code = 16'h0100;
            default: speed_code = 16'h0000;
        endcase
    endfunction

    function automatic logic [FRAME_BITS-1:0] build_frame(input mdio_cmd_t c);
        build_frame = {32'hFFFF_FFFF, 2'b01,
                       (c.rd ? 2'b10 : 2'b01),
                       c.dev, c.regad,
                       (c.rd ? 2'b11 : 2'b10),
                       (c.rd ? 16'hFFFF : c.wdata)};
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int CLK_DIV = 40
) (
    input  logic clk,
    input  logic rst_n,
    output logic mdc,
    output logic fall_tick,
    output logic rise_tick
);
    localparam int CW = $clog2(CLK_DIV + 1);

    logic [CW-1:0] cnt_q;
    logic          wrap;

    assign wrap      = (cnt_q == CW'(CLK_DIV - 1));
    assign fall_tick = wrap & mdc;
    assign rise_tick = wrap & ~mdc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fall_tick,
    input  logic        rise_tick,
    input  logic        go,
    input  mdio_cmd_t   cmd,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        fin,
    output logic [15:0] rdata
);
    localparam int BW = $clog2(FRAME_BITS + 1);

    frm_state_e            state_q, state_d;
    logic [FRAME_BITS-1:0] frame_q;
    logic [BW-1:0]         bit_cnt;
    logic                  is_rd;
    logic                  last;

    assign last = (bit_cnt == BW'(FRAME_BITS));
    assign fin  = (state_q == FRM_SHIFT) && fall_tick && last;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FRM_IDLE:  if (go) state_d = FRM_SHIFT;
            FRM_SHIFT: if (fall_tick && last) state_d = FRM_IDLE;
            default:   state_d = FRM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FRM_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q <= '0;
            bit_cnt <= '0;
            is_rd   <= 1'b0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
            rdata   <= '0;
        end else begin
            if (state_q == FRM_IDLE && go) begin
                frame_q <= build_frame(cmd);
                bit_cnt <= '0;
                is_rd   <= cmd.rd;
            end
            if (state_q == FRM_SHIFT && fall_tick) begin
                if (last) begin
                    mdio_o  <= 1'b1;
                    mdio_oe <= 1'b0;
                end else begin
                    mdio_o  <= frame_q[FRAME_BITS-1];
                    frame_q <= {frame_q[FRAME_BITS-2:0], 1'b1};
                    mdio_oe <= !(is_rd && (bit_cnt >= BW'(TA_POS)));
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
            if (state_q == FRM_SHIFT && rise_tick && is_rd &&
                (bit_cnt > BW'(DATA_POS)))
                rdata <= {rdata[14:0], mdio_i};
        end
    end
endmodule

// File: rtl/mdio_cfg_seq.sv
module mdio_cfg_seq
    import mdio_cfg_pkg::*;
#(
    parameter logic [4:0]  PHY_ADDR       = 5'd1,
    parameter logic [4:0]  CONV_A_ADDR    = 5'd7,
    parameter logic [4:0]  CONV_B_ADDR    = 5'd8,
    parameter logic [4:0]  CFG_REG        = 5'h10,
    parameter logic [4:0]  CTRL_REG       = 5'h00,
    parameter logic [15:0] AN_RESTART_VAL = 16'h1200,
    parameter logic [4:0]  STAT_REG       = 5'h11,
    parameter int          AN_BIT         = 11,
    parameter int          SPD_HI         = 15,
    parameter int          POLL_LIMIT     = 50000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        restart_an,
    input  logic        fin,
    input  logic [15:0] rdata,
    output logic        go,
    output mdio_cmd_t   cmd,
    output logic        busy,
    output logic        done,
    output logic        error,
    output logic [1:0]  speed
);
    localparam int PCW = $clog2(POLL_LIMIT + 1);

    seq_state_e     state_q, state_d;
    logic [PCW-1:0] poll_cnt;
    logic           an_ok_q;
    logic [1:0]     fld_q;
    logic [15:0]    code_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: if (start) state_d = restart_an ? SEQ_ANEG : SEQ_POLL;
            SEQ_ANEG: if (fin) state_d = SEQ_POLL;
            SEQ_POLL: if (fin) state_d = SEQ_EVAL;
            SEQ_EVAL: begin
                if (an_ok_q)
                    state_d = (fld_q == 2'b11) ? SEQ_FAIL : SEQ_WR_A;
                else if (poll_cnt == PCW'(POLL_LIMIT - 1))
                    state_d = SEQ_FAIL;
                else
                    state_d = SEQ_POLL;
            end
            SEQ_WR_A: if (fin) state_d = SEQ_WR_B;
            SEQ_WR_B: if (fin) state_d = SEQ_DONE;
            SEQ_DONE: state_d = SEQ_IDLE;
            SEQ_FAIL: state_d = SEQ_IDLE;
            default:  state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        go  = 1'b0;
        cmd = '{rd: 1'b0, dev: PHY_ADDR, regad: CTRL_REG, wdata: AN_RESTART_VAL};
        unique case (state_q)
            SEQ_ANEG: go = 1'b1;
            SEQ_POLL: begin
                go  = 1'b1;
                cmd = '{rd: 1'b1, dev: PHY_ADDR, regad: STAT_REG, wdata: 16'h0000};
            end
            SEQ_WR_A: begin
                go  = 1'b1;
                cmd = '{rd: 1'b0, dev: CONV_A_ADDR, regad: CFG_REG, wdata: code_q};
            end
            SEQ_WR_B: begin
                go  = 1'b1;
                cmd = '{rd: 1'b0, dev: CONV_B_ADDR, regad: CFG_REG, wdata: code_q};
            end
            default: go = 1'b0;
        endcase
    end

    assign busy = (state_q != SEQ_IDLE);
    assign done = (state_q == SEQ_DONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            poll_cnt <= '0;
            an_ok_q  <= 1'b0;
            fld_q    <= 2'b00;
            code_q   <= 16'h0000;
            error    <= 1'b0;
            speed    <= 2'b00;
        end else begin
            if (state_q == SEQ_IDLE && start) begin
                error    <= 1'b0;
                poll_cnt <= '0;
            end
            if (state_q == SEQ_POLL && fin) begin
                an_ok_q <= rdata[AN_BIT];
                fld_q   <= rdata[SPD_HI -: 2];
            end
            if (state_q == SEQ_EVAL) begin
                if (!an_ok_q)
                    poll_cnt <= poll_cnt + 1'b1;
                else if (fld_q != 2'b11) begin
                    code_q <= speed_code(fld_q);
                    speed  <= fld_q;
                end
            end
            if (state_d == SEQ_FAIL)
                error <= 1'b1;
        end
    end
endmodule

// File: rtl/mdio_speed_cfg.sv
module mdio_speed_cfg
    import mdio_cfg_pkg::*;
#(
    parameter int          CLK_DIV        = 40,
    parameter logic [4:0]  PHY_ADDR       = 5'd1,
    parameter logic [4:0]  CONV_A_ADDR    = 5'd7,
    parameter logic [4:0]  CONV_B_ADDR    = 5'd8,
    parameter logic [4:0]  CFG_REG        = 5'h10,
    parameter logic [4:0]  CTRL_REG       = 5'h00,
    parameter logic [15:0] AN_RESTART_VAL = 16'h1200,
    parameter logic [4:0]  STAT_REG       = 5'h11,
    parameter int          AN_BIT         = 11,
    parameter int          SPD_HI         = 15,
    parameter int          POLL_LIMIT     = 50000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       restart_an,
    input  logic       mdio_i,
    output logic       mdc,
    output logic       mdio_o,
    output logic       mdio_oe,
    output logic       busy,
    output logic       done,
    output logic       error,
    output logic [1:0] speed
);
    logic        fall_tick, rise_tick, go, fin;
    mdio_cmd_t   cmd;
    logic [15:0] rdata;

    mdio_mdc_gen #(.CLK_DIV(CLK_DIV)) u_mdc (
        .clk(clk), .rst_n(rst_n), .mdc(mdc),
        .fall_tick(fall_tick), .rise_tick(rise_tick)
    );

    mdio_frame_engine u_eng (
        .clk(clk), .rst_n(rst_n), .fall_tick(fall_tick), .rise_tick(rise_tick),
        .go(go), .cmd(cmd), .mdio_i(mdio_i), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .fin(fin), .rdata(rdata)
    );

    mdio_cfg_seq #(
        .PHY_ADDR(PHY_ADDR), .CONV_A_ADDR(CONV_A_ADDR), .CONV_B_ADDR(CONV_B_ADDR),
        .CFG_REG(CFG_REG), .CTRL_REG(CTRL_REG), .AN_RESTART_VAL(AN_RESTART_VAL),
        .STAT_REG(STAT_REG), .AN_BIT(AN_BIT), .SPD_HI(SPD_HI), .POLL_LIMIT(POLL_LIMIT)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .restart_an(restart_an),
        .fin(fin), .rdata(rdata), .go(go), .cmd(cmd), .busy(busy),
        .done(done), .error(error), .speed(speed)
    );
endmodule

// File: rtl/mdio_speed_cfg_chk.sv
module mdio_speed_cfg_chk (
    input logic clk,
    input logic rst_n,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe,
    input logic busy,
    input logic done,
    input logic error
);
    // R4
    mdo_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_o != $past(mdio_o)) |-> (!mdc && $past(mdc)));

    // R4
    oe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe != $past(mdio_oe)) |-> (!mdc && $past(mdc)));

    // R10
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !error);
endmodule

bind mdio_speed_cfg mdio_speed_cfg_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .busy(busy), .done(done), .error(error)
);

// File: tb/mdio_speed_cfg_bench.sv
`timescale 1ns/1ps
module mdio_speed_cfg_bench;
    localparam int          CLK_DIV    = 4;
    localparam int          POLL_LIMIT = 4;
    localparam logic [4:0]  PHY        = 5'd1;
    localparam logic [4:0]  STAT       = 5'h11;
    localparam logic [4:0]  CTRL       = 5'h00;
    localparam logic [15:0] RESTART    = 16'h1200;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, restart_an = 1'b0, mdio_i = 1'b1;
    logic mdc, mdio_o, mdio_oe, busy, done, error;
    logic [1:0] speed;

    always #2.5 clk = ~clk;

    mdio_speed_cfg #(.CLK_DIV(CLK_DIV), .POLL_LIMIT(POLL_LIMIT)) u_mdio_speed_cfg (
        .clk(clk), .rst_n(rst_n), .start(start), .restart_an(restart_an),
        .mdio_i(mdio_i), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .busy(busy), .done(done), .error(error), .speed(speed)
    );

    int checks = 0, failures = 0;
    bit finished = 0;

    // PHY / converter model state and logs
    logic [1:0]  m_spd;
    int          m_an_after;
    int          ones = 0, sl_st = 0, hcnt = 0, wcnt = 0, rd_idx = 0;
    logic [11:0] hdr;
    logic [17:0] wsh;
    logic [15:0] rd_val;
    int n_reads, n_ctrl, n_a, n_b, bad, ta_err, oe_err, order_err;
    logic [15:0] ctrl_val, a_val, b_val;
    bit conv_seen;

    task automatic clear_logs();
        n_reads = 0; n_ctrl = 0; n_a = 0; n_b = 0; bad = 0; ta_err = 0;
        oe_err = 0; order_err = 0; conv_seen = 0;
        ctrl_val = '0; a_val = '0; b_val = '0;
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    function automatic logic [15:0] exp_code(input logic [1:0] s);
        case (s)
            2'b10:   return 16'h0140;
            2'b01:   return 16'h2100;
            default: return 16'h0100;
        endcase
    endfunction

    task automatic log_write(input logic [4:0] dv, input logic [4:0] rg, input logic [15:0] d);
        if (dv == PHY && rg == CTRL) begin
            n_ctrl++; ctrl_val = d;
        end else if (dv == 5'd7 && rg == 5'h10) begin
            if (n_b != 0) order_err++;
            n_a++; a_val = d; conv_seen = 1;
        end else if (dv == 5'd8 && rg == 5'h10) begin
            if (n_a == 0) order_err++;
            n_b++; b_val = d; conv_seen = 1;
        end else bad++;
    endtask

    always @(posedge mdc) begin : slave_rx
        logic        b;
        logic [11:0] h;
        logic [17:0] w;
        b = mdio_oe ? mdio_o : 1'b1;
        case (sl_st)
            0: if (b) ones++;
               else begin sl_st = (ones >= 32) ? 1 : 0; ones = 0; end
            1: begin sl_st = b ? 2 : 0; hcnt = 0; end
            2: begin
                h = {hdr[10:0], b}; hdr = h; hcnt++;
                if (hcnt == 12) begin
                    if (h[11:10] == 2'b10) begin
                        if (h[9:5] == PHY && h[4:0] == STAT) begin
                            n_reads++;
                            if (conv_seen) order_err++;
                            rd_val = {m_spd, 2'b00,
                                      (m_an_after != 0 && n_reads >= m_an_after), 11'h000};
                        end else begin
                            bad++; rd_val = 16'hFFFF;
                        end
                        rd_idx = 0; sl_st = 4;
                    end else if (h[11:10] == 2'b01) begin
                        wcnt = 0; sl_st = 3;
                    end else begin
                        bad++; sl_st = 0; ones = 0;
                    end
                end
            end
            3: begin
                w = {wsh[16:0], b}; wsh = w; wcnt++;
                if (wcnt == 18) begin
                    if (w[17:16] != 2'b10) ta_err++;
                    log_write(hdr[9:5], hdr[4:0], w[15:0]);
                    sl_st = 0; ones = 0;
                end
            end
            4: if (mdio_oe) oe_err++;
            default: sl_st = 0;
        endcase
    end

    always @(negedge mdc) begin : slave_tx
        if (sl_st == 4) begin
            if (rd_idx == 0)       mdio_i = 1'b1;
            else if (rd_idx == 1)  mdio_i = 1'b0;
            else if (rd_idx <= 17) mdio_i = rd_val[17 - rd_idx];
            else begin mdio_i = 1'b1; sl_st = 0; ones = 0; end
            rd_idx++;
        end
    end

    task automatic run_case(input bit rs, input logic [1:0] spd, input int an_after, input bit poke);
        int  cyc, n_done;
        bit  exp_fail;
        int  exp_reads;
        clear_logs();
        m_spd = spd; m_an_after = an_after;
        @(negedge clk); start = 1'b1; restart_an = rs;
        @(negedge clk); start = 1'b0; restart_an = 1'b0;
        chk("R10 error cleared by start", {31'd0, error}, 32'd0);
        chk("R10 busy after start", {31'd0, busy}, 32'd1);
        cyc = 0; n_done = 0;
        while (busy && cyc < 20000) begin
            @(negedge clk); cyc++;
            if (done) n_done++;
            if (poke && cyc == 100) begin start = 1'b1; restart_an = 1'b1; end
            if (poke && cyc == 101) begin start = 1'b0; restart_an = 1'b0; end
        end
        chk("R10 job ends", {31'd0, busy}, 32'd0);
        exp_fail  = (an_after == 0) || (an_after > POLL_LIMIT) || (spd == 2'b11);
        exp_reads = ((an_after == 0) || (an_after > POLL_LIMIT)) ? POLL_LIMIT : an_after;
        chk("R8 done pulse count", n_done, exp_fail ? 0 : 1);
        chk("R5 status reads", n_reads, exp_reads);
        chk("R2 restart writes", n_ctrl, {31'd0, rs});
        if (rs) chk("R2 restart value", {16'd0, ctrl_val}, {16'd0, RESTART});
        chk("R3 frame decode", bad, 0);
        chk("R3 write turnaround", ta_err, 0);
        chk("R4 released during read", oe_err, 0);
        if (exp_fail) begin
            chk("R5 no converter writes on fail", n_a + n_b, 0);
        end else begin
            chk("R6 speed out", {30'd0, speed}, {30'd0, spd});
            chk("R7 conv A code", {16'd0, a_val}, {16'd0, exp_code(spd)});
            chk("R7 conv B code", {16'd0, b_val}, {16'd0, exp_code(spd)});
            chk("R7 one write each", n_a * 10 + n_b, 11);
            chk("R7 order", order_err, 0);
        end
        repeat (20) @(negedge clk);
        chk("R10 error held", {31'd0, error}, {31'd0, exp_fail});
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        realtime t0, t1;
        void'($urandom(32'd4242));
        clear_logs();
        m_spd = 2'b00; m_an_after = 1;
        repeat (5) @(negedge clk);
        chk("R1 mdc reset", {31'd0, mdc}, 32'd0);
        chk("R1 oe reset", {31'd0, mdio_oe}, 32'd0);
        chk("R1 mdio_o reset", {31'd0, mdio_o}, 32'd1);
        chk("R1 busy/done/error reset", {29'd0, busy, done, error}, 32'd0);
        rst_n = 1'b1;
        @(posedge mdc); t0 = $realtime;
        @(negedge mdc); t1 = $realtime;
        chk("R11 mdc high time", $rtoi(t1 - t0), CLK_DIV * 5);
        // directed corners
        run_case(1'b1, 2'b10, 1, 1'b0);            // R6 1G with restart
        run_case(1'b0, 2'b01, 2, 1'b0);            // R6 100M
        run_case(1'b0, 2'b00, 3, 1'b0);            // R6 10M
        run_case(1'b0, 2'b10, POLL_LIMIT, 1'b0);   // R5 last allowed poll
        run_case(1'b1, 2'b01, 0, 1'b0);            // R5 timeout
        run_case(1'b0, 2'b11, 2, 1'b0);            // R6 reserved speed
        run_case(1'b0, 2'b00, POLL_LIMIT + 1, 1'b0); // R5 one too late
        run_case(1'b0, 2'b10, 2, 1'b1);            // R9 start while busy
        // constrained random
        for (int i = 0; i < 10; i++) begin
            run_case(1'($urandom_range(0, 1)), 2'($urandom_range(0, 2)),
                     int'($urandom_range(1, POLL_LIMIT)), 1'b0);
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule